// File: doc/BRIEF.md
# Burst-of-Four Dual-Port Quad-Rate SRAM Core

This block is an on-chip static memory that reproduces the timing of a quad-data-rate SRAM with a fixed burst of four. It has one input data port and one output data port, and they run at the same time. The double data rate is modelled with one clock that runs at twice the command rate. On each rising edge of that clock, a phase output tells whether the edge acts as the K edge (the command edge) or as the complemented K# edge.

The shared address bus and the active-low read and write enables are sampled only on K edges. These K edges alternate between a read slot and a write slot. Each accepted command moves a burst of four 18-bit words. A word is made of two 9-bit byte lanes, and each lane has its own active-low write mask on every beat. The read data is driven 2.5 command cycles after the read command. It comes with a valid flag and with two echo strobes that mark which kind of edge launched each beat.

Top module: `qdr_b4_sram`

## Requirements
- R1: `k_phase_o` is 1 during reset and toggles on every rising edge of `clk_i`. A rising edge seen while `k_phase_o` is 1 is a K edge; any other rising edge is a K# edge. With this rule, the first edge after reset is K edge number 0.
- R2: Commands are accepted only on K edges. Even-numbered K edges form the read slot and odd-numbered K edges form the write slot. A low `rd_ni` outside the read slot has no effect, and neither has a low `wr_ni` outside the write slot.
- R3: Beat b (0 to 3) of a burst uses the word address formed by `{addr_i, b[1:0]}`, with the base address sampled with the command.
- R4: For a write accepted on edge m, beat b is taken from `d_i`/`bw_ni` on edge m+2+b. Beats 0 and 2 are therefore taken on K edges and beats 1 and 3 on K# edges. Data on all other edges is not stored.
- R5: On a write beat, `bw_ni[0]` low stores `d_i[8:0]` and `bw_ni[1]` low stores `d_i[17:9]`. A lane whose mask bit is high keeps its old content. The mask can differ from beat to beat.
- R6: For a read accepted on edge n, `q_o` holds beat b from edge n+5+b until the next edge. Beats 0 and 2 are launched on K# edges and beats 1 and 3 on K edges.
- R7: `valid_o` is 1 exactly while `q_o` holds a read beat. Whenever `valid_o` is 0, `q_o` is zero.
- R8: `cq_o` is 1 while a beat launched on a K edge is held, and `cqn_o` is 1 while a beat launched on a K# edge is held. Both are 0 when no beat is held.
- R9: Reads accepted in consecutive read slots give a gap-free stream of beats on `q_o`.
- R10: Each read beat returns the word contents as they stand on the edge that launches it. This includes every write beat stored on an earlier edge, so a read accepted on the K edge after a write to the same burst returns the new bytes.
- R11: Reset clears every stored word to zero and drives `q_o`, `valid_o`, `cq_o` and `cqn_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock; K and K# edges alternate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Burst base address, sampled on K edges |
| rd_ni | input | 1 | Read command, active low, read slot only |
| wr_ni | input | 1 | Write command, active low, write slot only |
| d_i | input | 18 | Write data beat |
| bw_ni | input | 2 | Per-lane write mask for the current beat, active low |
| q_o | output | 18 | Read data beat |
| valid_o | output | 1 | High while `q_o` holds a read beat |
| cq_o | output | 1 | Echo strobe for beats launched on K edges |
| cqn_o | output | 1 | Echo strobe for beats launched on K# edges |
| k_phase_o | output | 1 | High when the next rising edge is a K edge |

## Verification
All timing is counted in rising edges of the double-rate clock, numbered from the first edge after reset. A read accepted on edge n is due on `q_o` after edges n+5 to n+8. A write accepted on edge m samples its beats on edges m+2 to m+5. The bench schedules every input by edge number and runs a behavioural model on the same edges, with its own storage and its own queues of pending beats. It compares every output on the falling edge that follows each rising edge, so each result is read exactly one half period after the edge that launches it.

// File: rtl/qdr_b4_pkg.sv
package qdr_b4_pkg;
  localparam int unsigned LANE_W      = 9;
  localparam int unsigned LANES       = 2;
  localparam int unsigned BEATS       = 4;
  localparam int unsigned BEAT_W      = $clog2(BEATS);
  // latencies in double-rate clock edges
  localparam int unsigned RD_LAT_HALF = 5;
  localparam int unsigned WR_LAG_HALF = 2;
endpackage

// File: rtl/qdr_b4_phase.sv
module qdr_b4_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic k_phase_o,
  output logic rd_go_o,
  output logic wr_go_o
);
  logic kph_q;
  logic wslot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kph_q   <= 1'b1;
      wslot_q <= 1'b0;
    end else begin
      kph_q <= ~kph_q;
      if (kph_q) wslot_q <= ~wslot_q;
    end
  end

  assign k_phase_o = kph_q;
  assign rd_go_o   = kph_q & ~wslot_q & ~rd_ni;
  assign wr_go_o   = kph_q &  wslot_q & ~wr_ni;
endmodule

// File: rtl/qdr_b4_burst_seq.sv
module qdr_b4_burst_seq #(
  parameter  int unsigned AW  = 4,
  parameter  int unsigned DLY = 1,
  localparam int unsigned BW  = qdr_b4_pkg::BEAT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  output logic          act_o,
  output logic [BW-1:0] beat_o,
  output logic [AW+BW-1:0] word_o
);
  localparam logic [BW-1:0] LAST = BW'(qdr_b4_pkg::BEATS - 1);

  logic          stg_v [DLY];
  logic [AW-1:0] stg_a [DLY];
  logic [AW-1:0] base_q;
  logic [BW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DLY; i++) begin
        stg_v[i] <= 1'b0;
        stg_a[i] <= '0;
      end
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      stg_v[0] <= go_i;
      stg_a[0] <= addr_i;
      for (int i = 1; i < DLY; i++) begin
        stg_v[i] <= stg_v[i-1];
        stg_a[i] <= stg_a[i-1];
      end
      // a new burst takes over on the edge the previous one ends
      if (stg_v[DLY-1]) begin
        act_q  <= 1'b1;
        base_q <= stg_a[DLY-1];
        cnt_q  <= '0;
      end else if (act_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) act_q <= 1'b0;
      end
    end
  end

  assign act_o  = act_q;
  assign beat_o = cnt_q;
  assign word_o = {base_q, cnt_q};
endmodule

// File: rtl/qdr_b4_mem.sv
module qdr_b4_mem #(
  parameter  int unsigned WA     = 6,
  parameter  int unsigned LANE_W = 9,
  parameter  int unsigned LANES  = 2,
  localparam int unsigned WORDS  = 1 << WA,
  localparam int unsigned WORD_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  we_i,
  input  logic [WA-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WA-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] arr [WORDS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < WORDS; i++) arr[i] <= '0;
      end else if (we_i[l]) begin
        arr[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end

    assign rdata_o[l*LANE_W +: LANE_W] = arr[raddr_i];
  end
endmodule

// File: rtl/qdr_b4_rd_out.sv
module qdr_b4_rd_out #(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              beat_odd_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] q_o,
  output logic              valid_o,
  output logic              cq_o,
  output logic              cqn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      valid_o <= 1'b0;
      cq_o    <= 1'b0;
      cqn_o   <= 1'b0;
    end else if (act_i) begin
      q_o     <= rdata_i;
      valid_o <= 1'b1;
      cq_o    <= beat_odd_i;   // odd beats leave on K edges
      cqn_o   <= ~beat_odd_i;
    end else begin
      q_o     <= '0;
      valid_o <= 1'b0;
      cq_o    <= 1'b0;
      cqn_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram #(
  parameter  int unsigned BURSTS = 16,
  parameter  int unsigned LANE_W = qdr_b4_pkg::LANE_W,
  parameter  int unsigned LANES  = qdr_b4_pkg::LANES,
  localparam int unsigned AW     = $clog2(BURSTS),
  localparam int unsigned BW     = qdr_b4_pkg::BEAT_W,
  localparam int unsigned WA     = AW + BW,
  localparam int unsigned WORD_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [WORD_W-1:0] d_i,
  input  logic [LANES-1:0]  bw_ni,
  output logic [WORD_W-1:0] q_o,
  output logic              valid_o,
  output logic              cq_o,
  output logic              cqn_o,
  output logic              k_phase_o
);
  logic              rd_go, wr_go;
  logic              rd_act, wr_act;
  logic [BW-1:0]     rd_beat, wr_beat;
  logic [WA-1:0]     rd_word, wr_word;
  logic [LANES-1:0]  we;
  logic [WORD_W-1:0] rdata;

  qdr_b4_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_ni     (rd_ni),
    .wr_ni     (wr_ni),
    .k_phase_o (k_phase_o),
    .rd_go_o   (rd_go),
    .wr_go_o   (wr_go)
  );

  qdr_b4_burst_seq #(.AW(AW), .DLY(qdr_b4_pkg::WR_LAG_HALF - 1)) u_wr_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (wr_go),
    .addr_i (addr_i),
    .act_o  (wr_act),
    .beat_o (wr_beat),
    .word_o (wr_word)
  );

  qdr_b4_burst_seq #(.AW(AW), .DLY(qdr_b4_pkg::RD_LAT_HALF - 1)) u_rd_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (rd_go),
    .addr_i (addr_i),
    .act_o  (rd_act),
    .beat_o (rd_beat),
    .word_o (rd_word)
  );

  assign we = wr_act ? ~bw_ni : '0;

  qdr_b4_mem #(.WA(WA), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (wr_word),
    .wdata_i (d_i),
    .raddr_i (rd_word),
    .rdata_o (rdata)
  );

  qdr_b4_rd_out #(.WORD_W(WORD_W)) u_rd_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (rd_act),
    .beat_odd_i (rd_beat[0]),
    .rdata_i    (rdata),
    .q_o        (q_o),
    .valid_o    (valid_o),
    .cq_o       (cq_o),
    .cqn_o      (cqn_o)
  );

  logic unused_wr_beat;
  assign unused_wr_beat = ^wr_beat;
endmodule

// File: rtl/qdr_b4_sram_chk.sv
module qdr_b4_sram_chk #(
  parameter int unsigned WORD_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              k_phase_i,
  input logic              valid_i,
  input logic              cq_i,
  input logic              cqn_i,
  input logic [WORD_W-1:0] q_i,
  input logic              rd_go_i,
  input logic              wr_go_i,
  input logic              wr_act_i
);
  logic [2:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_q <= '0;
    else if (since_q != 3'd7)  since_q <= since_q + 3'd1;
  end

  // R7
  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (q_i == '0));

  // R8
  assert_strobe_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i == (cq_i | cqn_i) && $onehot0({cq_i, cqn_i}));

  // R8
  assert_cq_on_k_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q != 3'd0 && cq_i) |-> $past(k_phase_i));

  // R6
  assert_rd_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 3'd6 && $past(rd_go_i, 6)) |-> (valid_i && cqn_i));

  // R4
  assert_wr_lag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 3'd2 && $past(wr_go_i, 2)) |-> wr_act_i);
endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .k_phase_i (k_phase_o),
  .valid_i   (valid_o),
  .cq_i      (cq_o),
  .cqn_i     (cqn_o),
  .q_i       (q_o),
  .rd_go_i   (rd_go),
  .wr_go_i   (wr_go),
  .wr_act_i  (wr_act)
);

// File: tb/sim_qdr_b4_sram.sv
`timescale 1ns/1ps
module sim_qdr_b4_sram;
  localparam int NE = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        rd_n = 1'b1, wr_n = 1'b1;
  logic [17:0] d = '0;
  logic [1:0]  bw_n = 2'b11;
  logic [17:0] q;
  logic        valid, cq, cqn, kph;

  always #2.5 clk = ~clk;

  qdr_b4_sram u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_ni(rd_n), .wr_ni(wr_n),
    .d_i(d), .bw_ni(bw_n), .q_o(q), .valid_o(valid), .cq_o(cq), .cqn_o(cqn),
    .k_phase_o(kph)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // input schedule, indexed by edge number
  logic        s_rd [NE];
  logic        s_wr [NE];
  logic [3:0]  s_a  [NE];
  logic [17:0] s_d  [NE];
  logic [1:0]  s_bw [NE];

  // model state
  logic [17:0] mm [64];
  bit          rq_v [NE];
  int          rq_a [NE];
  int          rq_b [NE];
  bit          wq_v [NE];
  int          wq_a [NE];
  int          ecnt = 0;
  logic [17:0] e_q = '0;
  logic        e_v = 0, e_cq = 0, e_cqn = 0, e_k = 1;
  int          vcount = 0, run = 0, max_run = 0;

  function automatic logic [17:0] pat(int seed, int b);
    return 18'((seed * 32'h1f3 + b * 32'h0a5 + 32'h10101) & 32'h3ffff);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic sched_rd(int e, int base);
    s_rd[e] = 1'b0; s_a[e] = 4'(base);
  endtask

  // masks: two bits per beat, beat 0 in [1:0]
  task automatic sched_wr(int e, int base, int seed, logic [7:0] masks);
    s_wr[e] = 1'b0; s_a[e] = 4'(base);
    for (int b = 0; b < 4; b++) begin
      s_d[e+2+b]  = pat(seed, b);
      s_bw[e+2+b] = masks[2*b +: 2];
    end
  endtask

  // drive inputs for the coming edge
  always @(negedge clk) begin
    if (ecnt < NE) begin
      rd_n = s_rd[ecnt]; wr_n = s_wr[ecnt]; addr = s_a[ecnt];
      d = s_d[ecnt]; bw_n = s_bw[ecnt];
    end
  end

  // reference model, one step per rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      int e;
      e = ecnt;
      if (rq_v[e]) begin
        e_q = mm[rq_a[e]]; e_v = 1; e_cq = rq_b[e][0]; e_cqn = !rq_b[e][0];
      end else begin
        e_q = '0; e_v = 0; e_cq = 0; e_cqn = 0;
      end
      if (wq_v[e]) begin
        if (!bw_n[0]) mm[wq_a[e]][8:0]  = d[8:0];
        if (!bw_n[1]) mm[wq_a[e]][17:9] = d[17:9];
      end
      if (e % 2 == 0) begin
        if ((e / 2) % 2 == 0 && !rd_n)
          for (int b = 0; b < 4; b++) begin
            rq_v[e+5+b] = 1; rq_a[e+5+b] = int'(addr) * 4 + b; rq_b[e+5+b] = b;
          end
        if ((e / 2) % 2 == 1 && !wr_n)
          for (int b = 0; b < 4; b++) begin
            wq_v[e+2+b] = 1; wq_a[e+2+b] = int'(addr) * 4 + b;
          end
      end
      e_k = ((e + 1) % 2 == 0);
      ecnt = e + 1;
    end
  end

  // compare half a period after each edge
  always @(negedge clk) begin
    if (rst_n && ecnt > 0 && !done) begin
      chk("R3 R4 R5 R6 R10 q_o", 32'(q), 32'(e_q));
      chk("R6 R7 R9 valid_o", 32'(valid), 32'(e_v));
      chk("R8 cq_o", 32'(cq), 32'(e_cq));
      chk("R8 cqn_o", 32'(cqn), 32'(e_cqn));
      chk("R1 k_phase_o", 32'(kph), 32'(e_k));
      if (valid) begin
        vcount++; run++;
        if (run > max_run) max_run = run;
      end else run = 0;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      s_rd[i] = 1'b1; s_wr[i] = 1'b1; s_a[i] = 4'(i * 7);
      s_d[i] = 18'((i * 32'h0b5c3) ^ 32'h2aaaa);
      s_bw[i] = 2'b00;   // stray data would land if sampled off-beat (R4)
      rq_v[i] = 0; wq_v[i] = 0; rq_a[i] = 0; rq_b[i] = 0; wq_a[i] = 0;
    end
    for (int i = 0; i < 64; i++) mm[i] = '0;

    sched_rd(0, 3);                       // R11: cleared contents
    sched_wr(2, 3, 1, 8'h00);
    sched_rd(4, 3);                       // R10: next K edge after write
    sched_rd(8, 5);                       // R10: write commanded after read
    sched_wr(10, 5, 2, 8'b00_11_01_10);   // R5: per-beat masks
    sched_rd(12, 5);
    sched_rd(16, 5);                      // R9: back-to-back reads
    sched_rd(20, 3);
    s_rd[18] = 1'b0; s_a[18] = 4'd7;      // R2: read in write slot
    s_rd[17] = 1'b0; s_wr[17] = 1'b0;     // R2: K# edge
    s_wr[23] = 1'b0;
    s_wr[24] = 1'b0; s_a[24] = 4'd6;      // R2: write in read slot
    sched_rd(28, 6);
    sched_wr(30, 1, 3, 8'h00);
    sched_rd(32, 1);                      // concurrent read and write data
    sched_wr(34, 2, 4, 8'b01_00_10_00);
    sched_rd(36, 2);
    sched_wr(38, 1, 5, 8'b10_10_01_01);
    sched_rd(40, 1);
    sched_wr(42, 15, 6, 8'h00);           // R3: top burst
    sched_rd(44, 15);
    sched_rd(48, 0);

    repeat (3) @(negedge clk);
    chk("R11 q_o reset", 32'(q), 0);
    chk("R11 valid_o reset", 32'(valid), 0);
    chk("R11 cq_o reset", 32'(cq), 0);
    chk("R11 cqn_o reset", 32'(cqn), 0);
    chk("R1 k_phase_o reset", 32'(kph), 1);
    rst_n = 1'b1;

    repeat (66) @(negedge clk);
    chk("R2 R7 valid beat count", 32'(vcount), 48);
    chk("R9 longest gap-free run", 32'(max_run), 24);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule